// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Receiver

This block takes in 8-bit words from a clocked serial link made of one clock line and one data line. Bits enter a first-stage shift register, least significant bit first. When the eighth bit has arrived, the whole word moves into a holding register and a completion flag rises. That flag also serves as the interrupt request. The serial clock can come from either side. In clock-output mode the block makes it from the system clock with a fixed divider. In clock-input mode it samples an external clock through synchronizers.

Reception is paced by the reader. While the holding register is full, no clock pulse is produced and external clock edges are ignored. The holding register is presented as a valid/ready stream: `rd_valid` is the completion flag and `rd_data` is the word. When `rd_valid` and `rd_ready` are both high at a rising clock edge, the word counts as read. The flag clears at that edge and the receiver re-arms. `rd_data` does not change while `rd_valid` is high, so the reader may hold `rd_ready` low for as long as it needs.

Three plain control pins set the behaviour: a receive enable, a clock-source select and an edge select. Dropping the enable stops reception at once and throws away any partly received word.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_data` is 8'h00 and `sclk_out` is 1.
- R2: In clock-output mode (`ext_clk_mode`=0) with `rx_en`=1 and `rd_valid`=0, `sclk_out` gives exactly 8 pulses per word. Each pulse lasts 8 system clocks: 4 at the active level and 4 at the idle level. Between words the line rests at its idle level, which is 1 when `edge_sel`=0 and 0 when `edge_sel`=1.
- R3: In clock-output mode, data is sampled on the edge where `sclk_out` returns to idle, so it is rising when `edge_sel`=0 and falling when `edge_sel`=1. The first sampled bit becomes `rd_data[0]` and the eighth becomes `rd_data[7]`.
- R4: After the eighth sampled bit, `rd_valid` goes to 1 with the assembled word on `rd_data`. `rd_data` changes only when `rd_valid` rises.
- R5: While `rd_valid`=1, `sclk_out` stays at its idle level, external clock edges shift nothing, and `rd_data` and `rd_valid` hold until the handshake.
- R6: A cycle with `rd_valid`=1 and `rd_ready`=1 clears `rd_valid` at that clock edge. If `rx_en`=1, the next word then starts at once.
- R7: With `rx_en`=0, no clock pulses are produced, no external edges are taken, and `rd_valid` never rises.
- R8: In clock-input mode (`ext_clk_mode`=1), `sclk_in` and `sdata_in` each pass through two synchronizing flops. A bit is taken on a rising `sclk_in` edge when `edge_sel`=0 and on a falling edge when `edge_sel`=1. The data is filled into `rd_data` least significant bit first.
- R9: Dropping `rx_en` in the middle of a word discards the bits gathered so far and leaves `rd_data` unchanged. The next enabled word is assembled from its own 8 bits only.
- R10: In clock-input mode, `sclk_out` stays at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| edge_sel | input | 1 | 0: rising-edge sampling, 1: falling-edge sampling |
| ext_clk_mode | input | 1 | 0: block drives the serial clock, 1: serial clock comes from `sclk_in` |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Generated serial clock |
| sdata_in | input | 1 | Serial data |
| rd_valid | output | 1 | Word available (completion flag and interrupt request) |
| rd_ready | input | 1 | Reader accepts the word |
| rd_data | output | 8 | Received word |

## Verification
The hardest case to reach from the ports is a receive enable that drops partway through a word. That is the only way to show the partial bits are really discarded and not carried into the next word. The bench lets exactly three clock pulses go out carrying 1 bits, then drops the enable. It checks that the clock goes quiet and the old word survives. It then receives a fresh word whose low bits differ from the stale ones, so any leftover bits would show up. The sampling edge is tested by changing the data between the leading and trailing clock edges, so a receiver that samples on the wrong edge returns a shifted word.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int unsigned SSR_WORD_W  = 8;
  localparam int unsigned SSR_CLK_DIV = 8;
  localparam int unsigned SSR_SYNC    = 2;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_mode_e;

  // Resting level of the serial clock for a given sampling edge.
  function automatic logic idle_level(input edge_mode_e mode);
    return (mode == EDGE_RISE) ? 1'b1 : 1'b0;
  endfunction
endpackage

// File: rtl/ssr_clk_gen.sv
module ssr_clk_gen #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic idle_lvl,
  output logic sclk,
  output logic tick
);
  localparam int unsigned HALF  = DIV / 2;
  localparam int unsigned DIV_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [DIV_W-1:0] phase;
  logic             sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      sclk_q <= 1'b1;
    end else if (!run) begin
      phase  <= '0;
      sclk_q <= idle_lvl;
    end else begin
      phase  <= (phase == DIV_W'(DIV - 1)) ? '0 : phase + 1'b1;
      sclk_q <= idle_lvl ^ (phase < DIV_W'(HALF));
    end
  end

  // Sample on the same edge that returns the pin to its idle level.
  assign tick = run && (phase == DIV_W'(HALF));
  assign sclk = sclk_q;
endmodule

// File: rtl/ssr_edge_sync.sv
module ssr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic sdata_in,
  input  logic fall_mode,
  output logic act_edge,
  output logic data_s
);
  logic [STAGES:0]   cpipe;
  logic [STAGES-1:0] dpipe;

  for (genvar i = 0; i <= STAGES; i++) begin : g_cstage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) cpipe[0] <= 1'b0;
        else        cpipe[0] <= sclk_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) cpipe[i] <= 1'b0;
        else        cpipe[i] <= cpipe[i-1];
    end
  end

  for (genvar j = 0; j < STAGES; j++) begin : g_dstage
    if (j == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) dpipe[0] <= 1'b0;
        else        dpipe[0] <= sdata_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) dpipe[j] <= 1'b0;
        else        dpipe[j] <= dpipe[j-1];
    end
  end

  logic cur, prev;
  assign cur      = cpipe[STAGES-1];
  assign prev     = cpipe[STAGES];
  assign act_edge = fall_mode ? (prev & ~cur) : (cur & ~prev);
  assign data_s   = dpipe[STAGES-1];
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick,
  input  logic         bit_in,
  output logic         done,
  output logic [W-1:0] word
);
  localparam int unsigned CNT_W = (W > 2) ? $clog2(W) : 1;

  logic [W-1:0]     shreg;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      count <= '0;
    end else if (clear) begin
      shreg <= '0;
      count <= '0;
    end else if (tick) begin
      shreg <= {bit_in, shreg[W-1:1]};
      count <= (count == CNT_W'(W - 1)) ? '0 : count + 1'b1;
    end
  end

  assign done = tick && (count == CNT_W'(W - 1));
  assign word = {bit_in, shreg[W-1:1]};
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
  import ssr_pkg::*;
#(
  parameter int unsigned WORD_W      = SSR_WORD_W,
  parameter int unsigned CLK_DIV     = SSR_CLK_DIV,
  parameter int unsigned SYNC_STAGES = SSR_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              edge_sel,
  input  logic              ext_clk_mode,
  input  logic              sclk_in,
  output logic              sclk_out,
  input  logic              sdata_in,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data
);
  edge_mode_e        mode;
  logic              armed, gen_run, gen_tick, ext_edge, bit_s, tick, done;
  logic [WORD_W-1:0] word;
  logic              full_q;
  logic [WORD_W-1:0] hold_q;

  assign mode    = edge_mode_e'(edge_sel);
  assign armed   = rx_en && !full_q;
  assign gen_run = armed && !ext_clk_mode;
  assign tick    = ext_clk_mode ? (armed && ext_edge) : gen_tick;

  ssr_clk_gen #(.DIV(CLK_DIV)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (gen_run),
    .idle_lvl (idle_level(mode)),
    .sclk     (sclk_out),
    .tick     (gen_tick)
  );

  ssr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_in   (sclk_in),
    .sdata_in  (sdata_in),
    .fall_mode (mode == EDGE_FALL),
    .act_edge  (ext_edge),
    .data_s    (bit_s)
  );

  ssr_shifter #(.W(WORD_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (!rx_en),
    .tick   (tick),
    .bit_in (bit_s),
    .done   (done),
    .word   (word)
  );

  // Second stage: holding register and completion flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (done) begin
      full_q <= 1'b1;
      hold_q <= word;
    end else if (full_q && rd_ready) begin
      full_q <= 1'b0;
    end
  end

  assign rd_valid = full_q;
  assign rd_data  = hold_q;
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              edge_sel,
  input logic              ext_clk_mode,
  input logic              sclk_out,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [WORD_W-1:0] rd_data
);
  // R6
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> !rd_valid);

  // R5
  hold_until_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R4
  data_moves_on_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> rd_valid || $stable(rd_data));

  // R5
  clock_quiet_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(rd_valid) && $stable(edge_sel) |-> sclk_out == !edge_sel);

  // R10
  ext_mode_clock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clk_mode && $past(ext_clk_mode) && $stable(edge_sel) |-> sclk_out == !edge_sel);

  // R7
  disabled_no_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !$rose(rd_valid));
endmodule

bind sync_serial_rx ssr_checker #(.WORD_W(WORD_W)) u_ssr_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_en        (rx_en),
  .edge_sel     (edge_sel),
  .ext_clk_mode (ext_clk_mode),
  .sclk_out     (sclk_out),
  .rd_valid     (rd_valid),
  .rd_ready     (rd_ready),
  .rd_data      (rd_data)
);

// File: tb/sync_serial_rx_bench.sv
module sync_serial_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, edge_sel = 1'b0, ext_clk_mode = 1'b0;
  logic       sclk_in = 1'b0, sdata_in = 1'b0, rd_ready = 1'b0;
  logic       sclk_out, rd_valid;
  logic [7:0] rd_data;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sync_serial_rx u_sync_serial_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .edge_sel(edge_sel),
    .ext_clk_mode(ext_clk_mode), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .sdata_in(sdata_in), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data)
  );

  // {ext_clk_mode, edge_sel, word}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b0, 8'hA5},
    {1'b0, 1'b1, 8'h3C},
    {1'b1, 1'b0, 8'h96},
    {1'b1, 1'b1, 8'h01},
    {1'b0, 1'b0, 8'h80},
    {1'b1, 1'b0, 8'hFF}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Count leading (idle -> active) transitions of sclk_out over a window.
  task automatic count_leads(input int cycles, output int n);
    logic prev;
    n = 0;
    prev = sclk_out;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (sclk_out != prev && sclk_out == edge_sel) n++;
      prev = sclk_out;
    end
  endtask

  // Act as the sender in clock-output mode: new bit on each leading edge.
  task automatic recv_out(input logic [7:0] d, output int pulses, output int period);
    logic prev;
    int   t1, t2;
    pulses = 0; t1 = -1; t2 = -1;
    prev = sclk_out;
    for (int c = 0; c < 300 && !rd_valid; c++) begin
      @(negedge clk);
      if (sclk_out != prev && sclk_out == edge_sel) begin
        sdata_in = d[pulses & 7];
        if (pulses == 0) t1 = c;
        if (pulses == 1) t2 = c;
        pulses++;
      end
      prev = sclk_out;
    end
    period = t2 - t1;
  endtask

  // Drive an external clock; data changes just after the leading edge.
  task automatic send_ext(input logic [7:0] d);
    logic idle;
    idle = !edge_sel;
    sclk_in = idle;
    for (int i = 0; i < 8; i++) begin
      repeat (4) @(negedge clk);
      sclk_in = !idle;
      @(negedge clk);
      sdata_in = d[i];
      repeat (3) @(negedge clk);
      sclk_in = idle;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic do_read(input logic keep_en);
    @(negedge clk);
    rd_ready = 1'b1;
    rx_en = keep_en;
    @(negedge clk);
    rd_ready = 1'b0;
    chk(rd_valid == 1'b0, "R6 flag cleared by read", int'(rd_valid), 0);
  endtask

  initial begin
    int n, p, per;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R1 reset flag", int'(rd_valid), 0);
    chk(rd_data == 8'h00, "R1 reset data", int'(rd_data), 0);
    chk(sclk_out == 1'b1, "R1 reset clock level", int'(sclk_out), 1);

    // R7: disabled, clock-output mode
    count_leads(40, n);
    chk(n == 0, "R7 no pulses while disabled", n, 0);
    chk(rd_valid == 1'b0, "R7 no word while disabled", int'(rd_valid), 0);
    // R7: disabled, clock-input mode
    ext_clk_mode = 1'b1;
    send_ext(8'h5A);
    chk(rd_valid == 1'b0, "R7 external edges ignored while disabled", int'(rd_valid), 0);

    // Vector table
    for (int i = 0; i < 6; i++) begin
      rx_en = 1'b0;
      ext_clk_mode = VEC[i][9];
      edge_sel     = VEC[i][8];
      d            = VEC[i][7:0];
      sclk_in      = !edge_sel;
      repeat (4) @(negedge clk);
      rx_en = 1'b1;
      if (ext_clk_mode) begin
        send_ext(d);
        chk(sclk_out == !edge_sel, "R10 clock idle in input mode", int'(sclk_out), int'(!edge_sel));
        chk(rd_valid == 1'b1, "R4 flag after word (input mode)", int'(rd_valid), 1);
        chk(rd_data == d, "R8 word from external clock", int'(rd_data), int'(d));
        send_ext(~d);
        chk(rd_valid == 1'b1 && rd_data == d, "R5 external edges ignored while full",
            int'(rd_data), int'(d));
      end else begin
        recv_out(d, p, per);
        @(negedge clk);
        chk(p == 8, "R2 eight pulses per word", p, 8);
        chk(per == 8, "R2 pulse period", per, 8);
        chk(rd_valid == 1'b1, "R4 flag after word (output mode)", int'(rd_valid), 1);
        chk(rd_data == d, "R3 word from generated clock", int'(rd_data), int'(d));
        count_leads(30, n);
        chk(n == 0, "R5 clock stalls while full", n, 0);
        chk(sclk_out == !edge_sel, "R2 idle level between words", int'(sclk_out), int'(!edge_sel));
      end
      do_read(1'b0);
    end

    // R9: abort a word after three bits
    ext_clk_mode = 1'b0;
    edge_sel = 1'b0;
    sdata_in = 1'b1;
    repeat (4) @(negedge clk);
    rx_en = 1'b1;
    n = 0;
    for (int c = 0; c < 100 && n < 3; c++) begin
      logic prev;
      prev = sclk_out;
      @(negedge clk);
      if (sclk_out != prev && sclk_out == 1'b0) n++;
    end
    rx_en = 1'b0;
    count_leads(30, n);
    chk(n == 0, "R9 clock stops when disabled mid-word", n, 0);
    chk(rd_valid == 1'b0 && rd_data == 8'hFF, "R9 holding register kept", int'(rd_data), 8'hFF);
    rx_en = 1'b1;
    recv_out(8'h48, p, per);
    @(negedge clk);
    chk(rd_data == 8'h48, "R9 fresh word after abort", int'(rd_data), 8'h48);

    // R6: reading with the receiver enabled restarts the clock
    do_read(1'b1);
    count_leads(20, n);
    chk(n >= 1, "R6 reception resumes after read", n, 1);
    rx_en = 1'b0;
    repeat (10) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule